// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static memory with an internal two-bit burst counter. The array is two 9-bit lanes wide (18 bits) and has a parameterized depth. On each rising clock edge the block samples the address, three chip enables, two address strobes (a processor strobe and a controller strobe), the burst advance input, a global write and the byte-write controls. From these it decides whether the cycle deselects the device, starts a burst at an external address, continues the burst at the next internal address, or holds the current address as a wait state. Each active cycle is either a read or a write.

Reads are flow-through. The address is registered on the clock edge, and the array word at that address reaches the output in the same cycle, with no second register stage. The output enable and the snooze input act without waiting for a clock edge. The bidirectional data pad is split into a data output bus and a drive-enable flag.

A host uses the processor strobe for reads. It can follow a processor-strobe load with a write to the same address on the next edge. The controller strobe can start a read or a write directly. The burst order within an aligned group of four words is selected by a static mode input, either linear or interleaved.

Top module: `burst_sram`

## Requirements
- R1: After reset the device is deselected, has no burst active, and `dataOe` is 0.
- R2: When `procStrobeN`=0 and `ceN`=0 (and both secondary enables are active), the external address is loaded and a read starts. The write inputs and `ctrlStrobeN` have no effect on that edge, even when `ctrlStrobeN` is also 0. When `ceN`=1, `procStrobeN` is ignored.
- R3: When `ctrlStrobeN`=0, `procStrobeN`=1 and `ceN`=0, the external address is loaded and the cycle is a read or a write according to the write decode of R5. When `ctrlStrobeN`=0 and `ceN`=1, the device is deselected and `dataOe` goes to 0.
- R4: `ce2N` (active low) and `ce2` (active high) are sampled only on an address load. If either is inactive at a load, the device is deselected and `dataOe` is 0. During continue or suspend cycles their values have no effect.
- R5: The write decode works as follows:
  - `globalWrN`=0 writes both lanes.
  - Otherwise, with `byteWrEnN`=0, each `laneWrN[i]`=0 writes lane i. Lane 0 is `dataIn[8:0]`, including parity bit 8. Lane 1 is `dataIn[17:9]`, including parity bit 17.
  - With `globalWrN`=1 and `byteWrEnN`=1, the cycle is a read.
- R6: After a processor-strobe load, an edge with both strobes high, `advanceN`=1 and a write decoded writes the data to the address that was just loaded.
- R7: With both strobes high and the device selected:
  - `advanceN`=0 moves to the next burst address. `advanceN`=1 keeps the current address.
  - Only the low two address bits change. With `linearMode`=1 they step as (start+k) mod 4. With `linearMode`=0 they step as start XOR k.
  - After the fourth word the burst wraps to the start address.
- R8: Read data from the address registered at an edge appears on `dataOut` with `dataOe`=1 in the cycle that follows that edge. `outEnN`=1 forces `dataOe` to 0 at once, without waiting for a clock edge.
- R9: After a write cycle `dataOe` stays 0 until a later processor-strobe, controller-strobe or advance read cycle.
- R10: While `snooze`=1, `dataOe` is 0 at once, every other input is ignored, and the array and burst state are kept. When `snooze` falls, the device resumes in the state it held before snooze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrIn | input | ADDR_W | External word address |
| ceN | input | 1 | Primary chip enable, active low |
| ce2N | input | 1 | Secondary chip enable, active low, sampled on load |
| ce2 | input | 1 | Secondary chip enable, active high, sampled on load |
| procStrobeN | input | 1 | Processor address strobe, active low, read-only load |
| ctrlStrobeN | input | 1 | Controller address strobe, active low, read or write load |
| advanceN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Global write of both lanes, active low |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneWrN | input | 2 | Per-lane write enables, active low |
| linearMode | input | 1 | Burst order: 1 linear, 0 interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Asynchronous low-power hold, active high |
| dataIn | input | 18 | Write data |
| dataOut | output | 18 | Read data (0 when not driven) |
| dataOe | output | 1 | Data pad drive enable |

## Verification
Every result that depends on the clock is due in the cycle right after the edge that sampled the stimulus. This covers the loaded or advanced read word, the deselect and the high-Z after a write. The bench therefore drives all inputs one nanosecond after a rising edge and reads the outputs one nanosecond after the next rising edge. Output-enable and snooze effects have no clock in their path. They are checked one nanosecond after the input changes, with no edge in between. A write is checked through a later read, and a write that should not happen is checked by reading back the unchanged word.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANE_COUNT = 2;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic                  commit;   // update burst state on this edge
    logic                  loadExt;  // take the external address
    logic                  advance;  // step the burst counter
    logic [LANE_COUNT-1:0] laneWr;   // lanes written on this edge
  } ctrlStrobe_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  snooze,
  input  logic                  ceN,
  input  logic                  ce2N,
  input  logic                  ce2,
  input  logic                  procStrobeN,
  input  logic                  ctrlStrobeN,
  input  logic                  advanceN,
  input  logic                  globalWrN,
  input  logic                  byteWrEnN,
  input  logic [LANE_COUNT-1:0] laneWrN,
  input  logic                  outEnN,
  output ctrlStrobe_t           strobe,
  output logic                  driveEn
);
  logic selected, readPhase;
  logic selNext, readNext;
  logic [LANE_COUNT-1:0] wrLanes;
  logic secOk, procLoad, ctrlLoad;

  always_comb begin
    if (!globalWrN)      wrLanes = '1;
    else if (!byteWrEnN) wrLanes = ~laneWrN;
    else                 wrLanes = '0;
  end

  assign secOk    = !ce2N && ce2;
  assign procLoad = !procStrobeN && !ceN;
  assign ctrlLoad = !ctrlStrobeN && !procLoad;

  always_comb begin
    strobe   = '0;
    selNext  = selected;
    readNext = readPhase;
    if (procLoad) begin
      if (secOk) begin
        strobe.commit  = 1'b1;
        strobe.loadExt = 1'b1;
        selNext        = 1'b1;
        readNext       = 1'b1;
      end else begin
        selNext  = 1'b0;
        readNext = 1'b0;
      end
    end else if (ctrlLoad) begin
      if (!ceN && secOk) begin
        strobe.commit  = 1'b1;
        strobe.loadExt = 1'b1;
        strobe.laneWr  = wrLanes;
        selNext        = 1'b1;
        readNext       = (wrLanes == '0);
      end else begin
        selNext  = 1'b0;
        readNext = 1'b0;
      end
    end else if (selected) begin
      strobe.commit  = 1'b1;
      strobe.advance = !advanceN;
      strobe.laneWr  = wrLanes;
      readNext       = (wrLanes == '0);
    end
    if (snooze) begin
      strobe   = '0;
      selNext  = selected;
      readNext = readPhase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected  <= 1'b0;
      readPhase <= 1'b0;
    end else begin
      selected  <= selNext;
      readPhase <= readNext;
    end
  end

  assign driveEn = selected && readPhase && !outEnN && !snooze;
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  input  logic                         linearMode,
  input  logic [ADDR_W-1:0]            addrIn,
  input  logic [LANE_W*LANE_COUNT-1:0] dataIn,
  output logic [LANE_W*LANE_COUNT-1:0] readData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] burstCnt;
  logic [BURST_W-1:0] cycCnt;
  logic [ADDR_W-1:0]  curAddr;
  logic [ADDR_W-1:0]  cycAddr;

  function automatic logic [BURST_W-1:0] orderLow(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               linear
  );
    return linear ? BURST_W'(start + step) : (start ^ step);
  endfunction

  assign curAddr = {baseAddr[ADDR_W-1:BURST_W],
                    orderLow(baseAddr[BURST_W-1:0], burstCnt, linearMode)};

  always_comb begin
    if (strobe.loadExt)      cycCnt = '0;
    else if (strobe.advance) cycCnt = burstCnt + 1'b1;
    else                     cycCnt = burstCnt;
    if (strobe.loadExt) cycAddr = addrIn;
    else cycAddr = {baseAddr[ADDR_W-1:BURST_W],
                    orderLow(baseAddr[BURST_W-1:0], cycCnt, linearMode)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      burstCnt <= '0;
    end else if (strobe.commit) begin
      if (strobe.loadExt) baseAddr <= addrIn;
      burstCnt <= cycCnt;
    end
  end

  for (genvar g = 0; g < LANE_COUNT; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.commit && strobe.laneWr[g])
        laneMem[cycAddr] <= dataIn[g*LANE_W +: LANE_W];
    end
    assign readData[g*LANE_W +: LANE_W] = laneMem[curAddr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            addrIn,
  input  logic                         ceN,
  input  logic                         ce2N,
  input  logic                         ce2,
  input  logic                         procStrobeN,
  input  logic                         ctrlStrobeN,
  input  logic                         advanceN,
  input  logic                         globalWrN,
  input  logic                         byteWrEnN,
  input  logic [LANE_COUNT-1:0]        laneWrN,
  input  logic                         linearMode,
  input  logic                         outEnN,
  input  logic                         snooze,
  input  logic [LANE_W*LANE_COUNT-1:0] dataIn,
  output logic [LANE_W*LANE_COUNT-1:0] dataOut,
  output logic                         dataOe
);
  ctrlStrobe_t strobe;
  logic driveEn;
  logic [LANE_W*LANE_COUNT-1:0] readData;

  sram_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .snooze(snooze), .ceN(ceN), .ce2N(ce2N), .ce2(ce2),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .outEnN(outEnN), .strobe(strobe), .driveEn(driveEn)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .linearMode(linearMode),
    .addrIn(addrIn), .dataIn(dataIn), .readData(readData)
  );

  assign dataOe  = driveEn;
  assign dataOut = driveEn ? readData : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic ce2N,
  input logic ce2,
  input logic procStrobeN,
  input logic ctrlStrobeN,
  input logic globalWrN,
  input logic outEnN,
  input logic snooze,
  input logic dataOe
);
  // R10
  snooze_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    snooze |-> !dataOe);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataOe);

  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && !procStrobeN && !ceN && !ce2N && ce2) |=> (snooze || outEnN || dataOe));

  // R3
  ctrl_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && !ctrlStrobeN && ceN) |=> !dataOe);

  // R4
  sec_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && (!procStrobeN || !ctrlStrobeN) && !ceN && (ce2N || !ce2)) |=> !dataOe);

  // R9
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!snooze && procStrobeN && !ctrlStrobeN && !ceN && !globalWrN) |=> !dataOe);
endmodule

bind burst_sram burst_sram_chk uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .ce2N(ce2N), .ce2(ce2),
  .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .globalWrN(globalWrN),
  .outEnN(outEnN), .snooze(snooze), .dataOe(dataOe)
);

// File: tb/sim_burst_sram.sv
module sim_burst_sram;
  localparam int ADDR_W = 6;
  localparam int DW = 18;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic ceN = 1'b1, ce2N = 1'b1, ce2 = 1'b0;
  logic procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [1:0] laneWrN = 2'b11;
  logic linearMode = 1'b1, outEnN = 1'b0, snooze = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic dataOe;

  int tests = 0, fails = 0;
  logic [DW-1:0] refMem [DEPTH];

  always #2 clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ceN(ceN), .ce2N(ce2N), .ce2(ce2),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .linearMode(linearMode), .outEnN(outEnN), .snooze(snooze),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = 2'b11;
  endtask

  task automatic enable();
    ceN = 1'b0; ce2N = 1'b0; ce2 = 1'b1;
  endtask

  task automatic checkOut(input string tag, input logic expOe, input logic [DW-1:0] expData);
    tests++;
    if (dataOe !== expOe || (expOe && dataOut !== expData)) begin
      fails++;
      $display("FAIL %s: oe=%0b data=%05h expected oe=%0b data=%05h",
               tag, dataOe, dataOut, expOe, expData);
    end
  endtask

  function automatic int bAddr(int base, int k, int lin);
    int low;
    int ofs;
    low = base % 4;
    ofs = lin != 0 ? (low + k) % 4 : (low ^ (k % 4));
    return (base / 4) * 4 + ofs;
  endfunction

  task automatic procRead(input int a);
    quiet(); enable();
    procStrobeN = 1'b0; addrIn = ADDR_W'(a);
    tick();
  endtask

  task automatic ctrlWriteAll(input int a, input logic [DW-1:0] d);
    quiet(); enable();
    ctrlStrobeN = 1'b0; globalWrN = 1'b0; addrIn = ADDR_W'(a); dataIn = d;
    tick();
    refMem[a] = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [DW-1:0] d;
    logic [DW-1:0] exp;
    quiet();
    repeat (3) tick();
    // R1: reset state
    checkOut("R1 reset", 1'b0, '0);
    rstN = 1'b1;
    tick();
    checkOut("R1 idle after reset", 1'b0, '0);

    // R7 burst order sweep, R3 write via controller strobe, R9, R8 flow-through
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 4; s++) begin
        int base;
        base = (lin * 4 + s) * 4 + s;
        linearMode = lin[0];
        tick();
        for (int k = 0; k < 4; k++) begin
          quiet(); enable();
          d = DW'((lin * 1000 + s * 100 + k * 7 + 5) * 97);
          dataIn = d; globalWrN = 1'b0;
          if (k == 0) begin ctrlStrobeN = 1'b0; addrIn = ADDR_W'(base); end
          else advanceN = 1'b0;
          tick();
          refMem[bAddr(base, k, lin)] = d;
          checkOut("R9 no drive after write", 1'b0, '0);
        end
        for (int k = 0; k < 5; k++) begin
          quiet(); enable();
          if (k == 0) begin procStrobeN = 1'b0; addrIn = ADDR_W'(base); end
          else advanceN = 1'b0;
          tick();
          checkOut($sformatf("R7 R8 burst lin=%0d s=%0d k=%0d", lin, s, k), 1'b1,
                   refMem[bAddr(base, k % 4, lin)]);
        end
      end
    end
    linearMode = 1'b1;

    // R5 lane decode sweep
    for (int v = 0; v < 4; v++) begin
      ctrlWriteAll(50, 18'h3FFFF);
      quiet(); enable();
      ctrlStrobeN = 1'b0; byteWrEnN = 1'b0; laneWrN = 2'(v);
      addrIn = 6'd50; dataIn = 18'h0A5A5 + DW'(v);
      tick();
      exp = 18'h3FFFF;
      if (v[0] == 1'b0) exp[8:0]  = dataIn[8:0];
      if (v[1] == 1'b0) exp[17:9] = dataIn[17:9];
      refMem[50] = exp;
      procRead(50);
      checkOut($sformatf("R5 lanes laneWrN=%0d", v), 1'b1, exp);
    end
    // R5 byte-write enable high is a read
    quiet(); enable();
    ctrlStrobeN = 1'b0; byteWrEnN = 1'b1; laneWrN = 2'b00; addrIn = 6'd50; dataIn = 18'h11111;
    tick();
    checkOut("R5 R3 bwe high reads", 1'b1, refMem[50]);

    // R2 processor strobe precedence, write inputs ignored
    quiet(); enable();
    procStrobeN = 1'b0; ctrlStrobeN = 1'b0; globalWrN = 1'b0;
    addrIn = 6'd50; dataIn = 18'h2BEEF;
    tick();
    checkOut("R2 proc load reads old word", 1'b1, refMem[50]);
    // R6 deferred write to the loaded address
    quiet(); enable();
    globalWrN = 1'b0; dataIn = 18'h12345;
    tick();
    refMem[50] = 18'h12345;
    checkOut("R6 R9 deferred write no drive", 1'b0, '0);
    procRead(50);
    checkOut("R6 deferred write landed", 1'b1, 18'h12345);

    // R7 suspend and advance
    procRead(8);
    quiet();
    tick();
    checkOut("R7 suspend holds", 1'b1, refMem[8]);
    advanceN = 1'b0;
    tick();
    checkOut("R7 advance steps", 1'b1, refMem[9]);

    // R4 secondary enables
    quiet(); enable(); ce2 = 1'b0; procStrobeN = 1'b0; addrIn = 6'd8;
    tick();
    checkOut("R4 secondary inactive deselects", 1'b0, '0);
    procRead(8);
    quiet(); ceN = 1'b1; ce2N = 1'b1; ce2 = 1'b0; advanceN = 1'b0;
    tick();
    checkOut("R4 secondary ignored in burst", 1'b1, refMem[9]);

    // R3 controller strobe with primary high deselects
    quiet(); ceN = 1'b1; ctrlStrobeN = 1'b0; addrIn = 6'd8;
    tick();
    checkOut("R3 ctrl deselect", 1'b0, '0);
    // R2 processor strobe ignored with primary high
    quiet(); ceN = 1'b1; ce2N = 1'b0; ce2 = 1'b1; procStrobeN = 1'b0; addrIn = 6'd8;
    tick();
    checkOut("R2 proc ignored when ceN high", 1'b0, '0);

    // R8 asynchronous output enable
    procRead(8);
    quiet();
    outEnN = 1'b1; #1;
    checkOut("R8 oe high floats", 1'b0, '0);
    outEnN = 1'b0; #1;
    checkOut("R8 oe low drives", 1'b1, refMem[8]);

    // R10 snooze
    snooze = 1'b1; #1;
    checkOut("R10 snooze floats", 1'b0, '0);
    enable(); ctrlStrobeN = 1'b0; globalWrN = 1'b0; addrIn = 6'd8; dataIn = 18'h3C3C3;
    tick(); tick();
    checkOut("R10 snooze still floats", 1'b0, '0);
    quiet();
    snooze = 1'b0; #1;
    checkOut("R10 state and array kept", 1'b1, refMem[8]);

    // R9 write then advance read resumes drive
    ctrlWriteAll(20, 18'h0F0F0);
    checkOut("R9 write floats", 1'b0, '0);
    quiet(); enable(); advanceN = 1'b0;
    tick();
    checkOut("R9 advance read drives", 1'b1, refMem[21]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule